// File: doc/BRIEF.md
# Device Control and Performance Counter Registers

This block is a pair of byte-wide registers on a simple synchronous register bus inside a board controller. The control register is read/write. It holds an enable for a performance counter and three active-high reset lines, one each for a flash disk, a telephony switch and an Ethernet switch with its PHY. The second register is read-only. It holds an 8-bit counter that steps once per slow tick while enabled, and it is forced to zero while disabled.

A prescaler derives the counter tick from the system clock. With the default divide ratio of 64 at 100 MHz, the tick comes every 640 ns. The Ethernet reset has a minimum pulse width. Once it rises, it stays high for at least `ETH_MIN_CYC` system clocks, even if software clears its bit sooner. Bus writes take effect at the clock edge where `busWr` is sampled high. Reads are combinational from `busAddr`.

Top module: `devctl_regs`

## Requirements
- R1: The control register sits at address 0x15. A write stores bit 5 (counter enable), bit 2 (flash reset), bit 1 (telephony reset) and bit 0 (Ethernet reset), and a read returns those bits in the same positions.
- R2: Bits 7, 6, 4 and 3 of the control register always read as 0, whatever was written to them.
- R3: After reset, both registers read 0x00 and all three reset outputs are low.
- R4: `flashRst` equals control bit 2 and `telRst` equals control bit 1, from the edge of the write onward.
- R5: The counter register at address 0x16 is read-only. A write to it changes neither register.
- R6: While the enable bit is 0, the counter reads 0x00 and does not move, starting one clock after the enable is cleared.
- R7: While enabled, the counter increases by one every `TICK_DIV` clocks. After m clocks from the write that set the enable, it reads floor(m / `TICK_DIV`).
- R8: The counter wraps from 0xFF to 0x00 and keeps counting.
- R9: `ethRst` goes high at the edge of a write that sets control bit 0.
- R10: Every high pulse of `ethRst` lasts at least `ETH_MIN_CYC` clocks. If bit 0 is cleared earlier, the pulse lasts exactly `ETH_MIN_CYC` clocks from its rise.
- R11: If bit 0 stays set longer than the minimum, `ethRst` falls at the edge of the write that clears it.
- R12: Any address other than 0x15 and 0x16 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| flashRst | output | 1 | Flash disk reset, active high |
| telRst | output | 1 | Telephony switch reset, active high |
| ethRst | output | 1 | Ethernet switch and PHY reset, active high, width-stretched |

## Verification
A stuck or misloaded control bit shows up on the matching reset pin, or on the readback, at the first sample after the write edge. A prescaler that is off by one shows as a counter value that is off by one within a single tick period, and the error grows as the run goes on. The counter is read after several dozen ticks and again across the 0xFF wrap, so a late or missing wrap is caught as well.

A width counter that loads wrongly makes `ethRst` fall one cycle early or late. It also shows as a pulse that tracks the software bit too closely or lingers after a long hold. The bench samples the pin on the exact cycles around the minimum width and around the clearing write.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  localparam int CTRL_OFS  = 8'h15;
  localparam int CNT_OFS   = 8'h16;
  localparam int EN_BIT    = 5;
  localparam int FLASH_BIT = 2;
  localparam int TEL_BIT   = 1;
  localparam int ETH_BIT   = 0;

  typedef struct packed {
    logic cntEn;
    logic flashBit;
    logic telBit;
    logic ethBit;
  } ctrlCfg_t;
endpackage

// File: rtl/devctl_ctrl.sv
module devctl_ctrl
  import devctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic [7:0]        cntVal,
  output ctrlCfg_t          cfg,
  output logic [7:0]        busRdData
);
  logic ctrlHit, cntHit;
  logic unusedWrBits;

  assign ctrlHit = (busAddr == ADDR_W'(CTRL_OFS));
  assign cntHit  = (busAddr == ADDR_W'(CNT_OFS));
  assign unusedWrBits = ^{busWrData[7:6], busWrData[4:3]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (busWr && ctrlHit) begin
      cfg.cntEn    <= busWrData[EN_BIT];
      cfg.flashBit <= busWrData[FLASH_BIT];
      cfg.telBit   <= busWrData[TEL_BIT];
      cfg.ethBit   <= busWrData[ETH_BIT];
    end
  end

  always_comb begin
    busRdData = '0;
    if (ctrlHit) begin
      busRdData[EN_BIT]    = cfg.cntEn;
      busRdData[FLASH_BIT] = cfg.flashBit;
      busRdData[TEL_BIT]   = cfg.telBit;
      busRdData[ETH_BIT]   = cfg.ethBit;
    end else if (cntHit) begin
      busRdData = cntVal;
    end
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit |-> (busRdData[7:6] == 2'b00 && busRdData[4:3] == 2'b00));

  // R5
  cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && cntHit) |=> $stable(cfg));

  // R1
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && ctrlHit) |=> (cfg.cntEn == $past(busWrData[EN_BIT]) &&
                            cfg.ethBit == $past(busWrData[ETH_BIT])));
endmodule

// File: rtl/devctl_dp.sv
module devctl_dp
  import devctl_pkg::*;
#(
  parameter int TICK_DIV    = 64,
  parameter int ETH_MIN_CYC = 500
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlCfg_t cfg,
  output logic [7:0] cntVal,
  output logic     flashRst,
  output logic     telRst,
  output logic     ethRst
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int WID_W = $clog2(ETH_MIN_CYC + 1);

  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic [7:0]       cntQ;
  logic [WID_W-1:0] widthCnt;
  logic             stretchOn;

  assign tick = cfg.cntEn && (preCnt == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !cfg.cntEn) begin
      preCnt <= '0;
      cntQ   <= '0;
    end else if (tick) begin
      preCnt <= '0;
      cntQ   <= cntQ + 8'd1;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ethRst) begin
      widthCnt <= '0;
    end else if (widthCnt != WID_W'(ETH_MIN_CYC)) begin
      widthCnt <= widthCnt + WID_W'(1);
    end
  end

  assign stretchOn = (widthCnt != '0) && (widthCnt != WID_W'(ETH_MIN_CYC));
  assign ethRst    = cfg.ethBit | stretchOn;
  assign flashRst  = cfg.flashBit;
  assign telRst    = cfg.telBit;
  assign cntVal    = cntQ;

  // R6
  cnt_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.cntEn |=> (cntVal == 8'h00));

  // R7
  cnt_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.cntEn && !tick) |=> $stable(cntVal));

  logic [WID_W-1:0] hiRun;
  always_ff @(posedge clk) begin
    if (!rstN || !ethRst) hiRun <= '0;
    else if (hiRun != WID_W'(ETH_MIN_CYC)) hiRun <= hiRun + WID_W'(1);
  end

  // R10
  eth_min_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ethRst) |-> (hiRun == WID_W'(ETH_MIN_CYC)));

  // R9
  eth_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.ethBit |-> ethRst);
endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
  import devctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TICK_DIV    = 64,
  parameter int ETH_MIN_CYC = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              flashRst,
  output logic              telRst,
  output logic              ethRst
);
  ctrlCfg_t   cfg;
  logic [7:0] cntVal;

  devctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .cntVal(cntVal), .cfg(cfg), .busRdData(busRdData)
  );

  devctl_dp #(.TICK_DIV(TICK_DIV), .ETH_MIN_CYC(ETH_MIN_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .cntVal(cntVal),
    .flashRst(flashRst), .telRst(telRst), .ethRst(ethRst)
  );
endmodule

// File: tb/devctl_regs_bench.sv
module devctl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int EMIN = 10;

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0, busRdData;
  logic flashRst, telRst, ethRst;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  devctl_regs #(.ADDR_W(8), .TICK_DIV(TDIV), .ETH_MIN_CYC(EMIN)) u_devctl_regs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .flashRst(flashRst), .telRst(telRst), .ethRst(ethRst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic tReset();
    logic [7:0] d;
    busRead(8'h15, d); chk("R3 ctrl", d, 8'h00);
    busRead(8'h16, d); chk("R3 cnt", d, 8'h00);
    chk("R3 outputs", {5'b0, flashRst, telRst, ethRst}, 8'h00);
  endtask

  task automatic tCtrlRw();
    logic [7:0] d;
    busWrite(8'h15, 8'hFF);
    busRead(8'h15, d); chk("R1/R2 readback", d, 8'h27);
    chk("R4 both set", {6'b0, flashRst, telRst}, 8'h03);
    busWrite(8'h15, 8'hDC);
    busRead(8'h15, d); chk("R2 reserved", d, 8'h04);
    chk("R4 flash only", {6'b0, flashRst, telRst}, 8'h02);
    busWrite(8'h15, 8'h02);
    chk("R4 tel only", {6'b0, flashRst, telRst}, 8'h01);
    busWrite(8'h15, 8'h00);
    repeat (20) @(negedge clk);
  endtask

  task automatic tUnmapped();
    logic [7:0] d;
    busWrite(8'h40, 8'hFF);
    busRead(8'h40, d); chk("R12 unmapped read", d, 8'h00);
    busRead(8'h15, d); chk("R12 ctrl untouched", d, 8'h00);
  endtask

  task automatic tCntReadOnly();
    logic [7:0] d;
    busWrite(8'h16, 8'hAA);
    busRead(8'h15, d); chk("R5 ctrl unchanged", d, 8'h00);
    busRead(8'h16, d); chk("R5 cnt unchanged", d, 8'h00);
  endtask

  task automatic tCntHold();
    logic [7:0] d;
    repeat (50) @(negedge clk);
    busRead(8'h16, d); chk("R6 disabled hold", d, 8'h00);
  endtask

  task automatic tCntRun();
    logic [7:0] d;
    busWrite(8'h15, 8'h20);               // m = 0
    repeat (3) @(negedge clk);            // m = 3
    busRead(8'h16, d); chk("R7 before tick", d, 8'h00);
    @(negedge clk);                       // m = 4
    busRead(8'h16, d); chk("R7 first tick", d, 8'h01);
    repeat (36) @(negedge clk);           // m = 40
    busRead(8'h16, d); chk("R7 ten ticks", d, 8'h0A);
    busWrite(8'h16, 8'h00);               // m = 41
    busRead(8'h16, d); chk("R5 write to cnt ignored", d, 8'h0A);
    repeat (979) @(negedge clk);          // m = 1020
    busRead(8'h16, d); chk("R8 at max", d, 8'hFF);
    repeat (4) @(negedge clk);            // m = 1024
    busRead(8'h16, d); chk("R8 wrap", d, 8'h00);
    repeat (4) @(negedge clk);            // m = 1028
    busRead(8'h16, d); chk("R8 after wrap", d, 8'h01);
    busWrite(8'h15, 8'h00);
    @(negedge clk);
    busRead(8'h16, d); chk("R6 cleared on disable", d, 8'h00);
    repeat (10) @(negedge clk);
    busRead(8'h16, d); chk("R6 stays zero", d, 8'h00);
  endtask

  task automatic tEthEarly();
    busWrite(8'h15, 8'h01);               // j = 0
    chk("R9 rise", {7'b0, ethRst}, 8'h01);
    busWrite(8'h15, 8'h00);               // j = 1
    chk("R10 stretched", {7'b0, ethRst}, 8'h01);
    repeat (EMIN - 2) @(negedge clk);     // j = EMIN-1
    chk("R10 last high cycle", {7'b0, ethRst}, 8'h01);
    @(negedge clk);                       // j = EMIN
    chk("R10 released", {7'b0, ethRst}, 8'h00);
  endtask

  task automatic tEthHold();
    busWrite(8'h15, 8'h01);
    repeat (20) @(negedge clk);
    chk("R11 held", {7'b0, ethRst}, 8'h01);
    busWrite(8'h15, 8'h00);
    chk("R11 immediate release", {7'b0, ethRst}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCtrlRw();
    tUnmapped();
    tCntReadOnly();
    tCntHold();
    tCntRun();
    tEthEarly();
    tEthHold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule